// File: doc/BRIEF.md
# Carry-free approximate signed-digit plus binary adder

This block adds a signed-digit operand to an unsigned binary operand of the same width and returns the sum as a signed-digit number that is one digit wider. Each signed digit is carried on two wires, a positive wire and a negative wire, and takes the value positive minus negative. Every output bit is a function of the inputs at a single digit position. No carry travels along the word, so the delay does not grow with the width.

The upper part of the word uses exact digit cells. The lower part uses a reduced cell with less logic. In the reduced cell the transfer bit sent to the next position is a plain copy of the positive wire of the input digit. The split is fixed when the block is elaborated. When every cell is exact the result is bit-exact. Otherwise the result differs from the true sum only by an error term whose size is known in advance. The block is purely combinational, so a datapath can place registers around it wherever it needs them. Converting the result back to binary is left to the logic that consumes it.

Top module: `approx_sd_adder`

## Requirements
- R1: The signed-digit encoding uses (pos,neg) pairs with value pos−neg: 00 and 11 stand for 0, 10 for +1 and 01 for −1. The result value is the sum over i = 0..DIGITS of (sum_pos[i] − sum_neg[i])·2^i.
- R2: In every position i < DIGITS, sum_neg[i] = a_pos[i] XOR a_neg[i] XOR b_bin[i].
- R3: In an exact position (i ≥ DIGITS−EXACT_DIGITS), sum_pos[i+1] is 1 exactly when the triple (a_pos[i],a_neg[i],b_bin[i]) is 001, 100, 101 or 111. This makes 2·sum_pos[i+1] − sum_neg[i] equal a_pos[i] − a_neg[i] + b_bin[i].
- R4: In an approximate position (i < DIGITS−EXACT_DIGITS), sum_pos[i+1] = a_pos[i].
- R5: sum_pos[0] is always 0 and sum_neg[DIGITS] is always 0.
- R6: With EXACT_DIGITS = DIGITS, the decoded result equals the signed-digit value of a plus b_bin, for every input.
- R7: With EXACT_DIGITS < DIGITS, the decoded result minus the true sum equals the sum over approximate positions i of +2^(i+1) for the triple 110 and −2^(i+1) for the triple 001, where the triple is (a_pos[i],a_neg[i],b_bin[i]). The magnitude of this error never exceeds 2^(DIGITS−EXACT_DIGITS+1) − 2.
- R8: Changing the inputs of a single position j changes no output other than sum_neg[j] and sum_pos[j+1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_pos | input | DIGITS | Positive wires of the signed-digit operand |
| a_neg | input | DIGITS | Negative wires of the signed-digit operand |
| b_bin | input | DIGITS | Unsigned binary operand |
| sum_pos | output | DIGITS+1 | Positive wires of the signed-digit result |
| sum_neg | output | DIGITS+1 | Negative wires of the signed-digit result |

## Verification
Each output bit depends on the inputs of one position only. A wrong cell function therefore shows up right away at that cell's own two output bits, with no delay, and the bench compares every bit against the cell rules for every input at a four-digit width. A cell placed on the wrong side of the exact/approximate split, or a cell whose transfer function is wrong, changes the decoded value. The bench catches this by comparing against the arithmetic sum plus the predicted error term, for three split settings. A wire crossing between positions breaks locality, and the bench detects it by flipping one position at a time.

// File: rtl/approx_sd_pkg.sv
package approx_sd_pkg;

  // One signed digit: value is pos - neg
  typedef struct packed {
    logic pos;
    logic neg;
  } sd_digit_t;

endpackage

// File: rtl/sd_cell_exact.sv
module sd_cell_exact
  import approx_sd_pkg::*;
(
  input  sd_digit_t xd,
  input  logic      yb,
  output logic      sm,
  output logic      tx
);

  always_comb begin
    sm = xd.pos ^ xd.neg ^ yb;
    // majority of (pos, ~neg, y)
    tx = (xd.pos & ~xd.neg) | (xd.pos & yb) | (~xd.neg & yb);
  end

  // R3: the digit's value is preserved across the (transfer, local) pair
  always_comb begin
    a_r3_digit_identity: assert ((int'(xd.pos) - int'(xd.neg) + int'(yb)) ==
                                 (2 * int'(tx) - int'(sm)))
      else $error("exact cell loses value");
  end

endmodule

// File: rtl/sd_cell_approx.sv
module sd_cell_approx
  import approx_sd_pkg::*;
(
  input  sd_digit_t xd,
  input  logic      yb,
  output logic      sm,
  output logic      tx
);

  always_comb begin
    sm = xd.pos ^ xd.neg ^ yb;
    tx = xd.pos;
  end

  // R7: a local mismatch only arises for triples 110 and 001
  always_comb begin
    if ((int'(xd.pos) - int'(xd.neg) + int'(yb)) != (2 * int'(tx) - int'(sm))) begin
      a_r7_error_pattern: assert ((xd.pos == xd.neg) && (yb != xd.pos))
        else $error("approximate cell error on unexpected triple");
    end
  end

endmodule

// File: rtl/approx_sd_adder.sv
module approx_sd_adder
  import approx_sd_pkg::*;
#(
  parameter int DIGITS       = 16,
  parameter int EXACT_DIGITS = 8
) (
  input  logic [DIGITS-1:0] a_pos,
  input  logic [DIGITS-1:0] a_neg,
  input  logic [DIGITS-1:0] b_bin,
  output logic [DIGITS:0]   sum_pos,
  output logic [DIGITS:0]   sum_neg
);

  localparam int APPROX_DIGITS = DIGITS - EXACT_DIGITS;
  localparam longint ERR_BOUND = (longint'(1) <<< (APPROX_DIGITS + 1)) - 2;

  // R5: fixed boundary digits
  assign sum_pos[0]      = 1'b0;
  assign sum_neg[DIGITS] = 1'b0;

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_pos
    sd_digit_t dig;
    assign dig.pos = a_pos[gi];
    assign dig.neg = a_neg[gi];
    if (gi >= APPROX_DIGITS) begin : g_exact
      sd_cell_exact u_cell (
        .xd (dig),
        .yb (b_bin[gi]),
        .sm (sum_neg[gi]),
        .tx (sum_pos[gi+1])
      );
    end else begin : g_approx
      sd_cell_approx u_cell (
        .xd (dig),
        .yb (b_bin[gi]),
        .sm (sum_neg[gi]),
        .tx (sum_pos[gi+1])
      );
    end
  end

  // Whole-word value checks (R6, R7)
  logic signed [63:0] chk_result;
  logic signed [63:0] chk_truth;

  always_comb begin
    chk_result = '0;
    chk_truth  = '0;
    for (int i = 0; i <= DIGITS; i++) begin
      chk_result = chk_result +
        ((longint'(sum_pos[i]) - longint'(sum_neg[i])) <<< i);
    end
    for (int i = 0; i < DIGITS; i++) begin
      chk_truth = chk_truth +
        ((longint'(a_pos[i]) - longint'(a_neg[i]) + longint'(b_bin[i])) <<< i);
    end
  end

  always_comb begin
    if (APPROX_DIGITS == 0) begin
      a_r6_exact_total: assert (chk_result == chk_truth)
        else $error("exact configuration result differs from sum");
    end
    a_r7_error_bound: assert ((chk_result - chk_truth <= ERR_BOUND) &&
                              (chk_truth - chk_result <= ERR_BOUND))
      else $error("approximation error beyond bound");
  end

endmodule

// File: tb/approx_sd_adder_tb_top.sv
module approx_sd_adder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [ND-1:0] ap, an, bb;
  logic [ND:0]   p2, n2, p4, n4, p0, n0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  approx_sd_adder #(.DIGITS(ND), .EXACT_DIGITS(2)) dut_i (
    .a_pos(ap), .a_neg(an), .b_bin(bb), .sum_pos(p2), .sum_neg(n2));
  approx_sd_adder #(.DIGITS(ND), .EXACT_DIGITS(ND)) dut_exact_i (
    .a_pos(ap), .a_neg(an), .b_bin(bb), .sum_pos(p4), .sum_neg(n4));
  approx_sd_adder #(.DIGITS(ND), .EXACT_DIGITS(0)) dut_zero_i (
    .a_pos(ap), .a_neg(an), .b_bin(bb), .sum_pos(p0), .sum_neg(n0));

  function automatic int decode(input logic [ND:0] p, input logic [ND:0] n);
    int v = 0;
    for (int i = 0; i <= ND; i++) v += (int'(p[i]) - int'(n[i])) * (1 << i);
    return v;
  endfunction

  task automatic check_one(input int k, input logic [ND:0] p, input logic [ND:0] n);
    int truth, err, got, bound;
    logic [ND-1:0] exp_n, exp_p;
    truth = 0; err = 0;
    for (int i = 0; i < ND; i++) begin
      logic [2:0] t;
      t = {ap[i], an[i], bb[i]};
      truth += (int'(ap[i]) - int'(an[i]) + int'(bb[i])) * (1 << i);
      exp_n[i] = ^t;
      if (i >= ND - k) exp_p[i] = (t == 3'b001) || (t == 3'b100) || (t == 3'b101) || (t == 3'b111);
      else begin
        exp_p[i] = ap[i];
        if (t == 3'b110) err += 2 << i;
        if (t == 3'b001) err -= 2 << i;
      end
    end
    got = decode(p, n);
    bound = (2 << (ND - k)) - 2;

    checks++;
    if (p[0] !== 1'b0 || n[ND] !== 1'b0) begin
      errors++; $display("FAIL R5 k=%0d got p0=%b nTop=%b exp 0 0", k, p[0], n[ND]);
    end
    checks++;
    if (n[ND-1:0] !== exp_n) begin
      errors++; $display("FAIL R2 k=%0d got %b exp %b", k, n[ND-1:0], exp_n);
    end
    checks++;
    if (p[ND:1] !== exp_p) begin
      errors++; $display("FAIL R3/R4 k=%0d got %b exp %b", k, p[ND:1], exp_p);
    end
    checks++;
    if (got != truth + err) begin
      errors++;
      if (k == ND) $display("FAIL R6 k=%0d got %0d exp %0d", k, got, truth);
      else $display("FAIL R7 k=%0d got %0d exp %0d", k, got, truth + err);
    end
    checks++;
    if (got - truth > bound || truth - got > bound) begin
      errors++; $display("FAIL R7 bound k=%0d got err %0d exp within %0d", k, got - truth, bound);
    end
  endtask

  initial begin
    ap = '0; an = '0; bb = '0;
    @(posedge clk); @(negedge clk);
    // Idle: all-zero inputs give an all-zero result (R1)
    checks++;
    if (p2 !== '0 || n2 !== '0) begin
      errors++; $display("FAIL R1 idle got %b/%b exp 0/0", p2, n2);
    end
    // Exhaustive sweep over all three operand words
    for (int v = 0; v < (1 << (3*ND)); v++) begin
      @(posedge clk);
      ap = v[ND-1:0]; an = v[2*ND-1:ND]; bb = v[3*ND-1:2*ND];
      @(negedge clk);
      check_one(2, p2, n2);
      check_one(ND, p4, n4);
      check_one(0, p0, n0);
    end
    // R8: flip one position at a time, other outputs must hold
    for (int v = 0; v < (1 << (3*ND)); v += 13) begin
      for (int j = 0; j < ND; j++) begin
        logic [ND:0] bp, bn, mask_p, mask_n;
        @(posedge clk);
        ap = v[ND-1:0]; an = v[2*ND-1:ND]; bb = v[3*ND-1:2*ND];
        @(negedge clk);
        bp = p2; bn = n2;
        @(posedge clk);
        ap[j] = ~ap[j]; an[j] = (v[j] ^ v[ND+j]) ? an[j] : ~an[j]; bb[j] = ~bb[j];
        @(negedge clk);
        mask_p = ~((ND+1)'(1) << (j+1));
        mask_n = ~((ND+1)'(1) << j);
        checks++;
        if (((p2 ^ bp) & mask_p) != '0 || ((n2 ^ bn) & mask_n) != '0) begin
          errors++;
          $display("FAIL R8 j=%0d got %b/%b exp %b/%b outside position", j, p2, n2, bp, bn);
        end
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired got %0d cycles exp fewer", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule